// File: doc/BRIEF.md
# Card Host Data FIFO with Watermark Requests

This block is the data buffer that sits between the register interface and the card-side byte engine of a memory-card host controller. It stores 16-bit words in a 32-entry circular buffer. The transfer direction decides who fills and who drains it. When receiving, the card side pushes and the register side pops. When transmitting, the register side pushes and the card side pops.

The fill level is compared with two programmable watermarks: an almost-full level used while receiving and an almost-empty level used while transmitting. A crossing goes to one of two places. If DMA is enabled for that direction, a level-sensitive DMA request is raised. If not, a status flag is set for software polling or for an interrupt. The block also holds the buffer-configuration register and the status word, which has sticky event bits set by neighbouring logic. It drives the interrupt output from the status word and an interrupt-enable mask.

Top module: `mmc_data_fifo`

## Requirements
- R1: After reset the fill level is 0 and both DMA requests are low. The interrupt output is low. The configuration read-back is 0x1F00, which means almost-full level 31, almost-empty level 0 and both DMA enables off.
- R2: Words leave in the order they entered, across wrap of the 32-entry buffer. With `dir_rx`=1 the card side pushes and the register side pops. With `dir_rx`=0 the register side pushes and the card side pops. `fill_level` follows each accepted push or pop one cycle later.
- R3: A push while 32 words are held is discarded: the fill level stays 32 and the stored words are unchanged.
- R4: A pop while empty does nothing. The fill level stays 0 and the read data keeps showing the word at the head index.
- R5: A push and a pop in the same cycle are judged against the fill level before that cycle. At a level between 1 and 31 the level is unchanged. When full, only the pop takes effect, giving 31. When empty, only the push takes effect, giving 1.
- R6: While receiving, if the fill level is greater than the almost-full level, then `rx_dma_req` is high when receive DMA is enabled and status bit 10 is set when it is not. Otherwise both are low.
- R7: While transmitting, if the fill level is less than the almost-empty level, then `tx_dma_req` is high when transmit DMA is enabled and status bit 11 is set when it is not. Otherwise both are low.
- R8: With no transfer active and the buffer empty, status bits 10 and 11 and both DMA requests are low.
- R9: The configuration word has receive DMA enable at bit 15, almost-full level at bits 12:8, transmit DMA enable at bit 7 and almost-empty level at bits 4:0. Other bits read 0. Writing it with a DMA enable set clears the matching status flag from the next cycle.
- R10: Status bits other than 10 and 11 are sticky. A pulse on `status_set` sets them and a write of ones on the clear port clears them; when both happen in the same cycle, the set wins. The clear port cannot change bits 10 and 11.
- R11: `irq` is high exactly when status AND mask is nonzero. Bit 15 of a mask write is discarded.
- R12: `fifo_flush` empties the buffer and returns the head index to 0 in the next cycle, overriding any push or pop in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dir_rx | input | 1 | 1 = receive (card to host), 0 = transmit |
| xfer_active | input | 1 | A data transfer is in progress |
| fifo_flush | input | 1 | Empty the buffer |
| reg_wr_en | input | 1 | Register-side push strobe (used in transmit) |
| reg_wr_data | input | 16 | Register-side push word |
| reg_rd_en | input | 1 | Register-side pop strobe (used in receive) |
| reg_rd_data | output | 16 | Word at the head index |
| card_push | input | 1 | Card-side push strobe (used in receive) |
| card_push_data | input | 16 | Card-side push word |
| card_pop | input | 1 | Card-side pop strobe (used in transmit) |
| card_pop_data | output | 16 | Word at the head index |
| fill_level | output | 6 | Number of words held |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 16 | Configuration write word |
| cfg_rd_data | output | 16 | Configuration read-back |
| mask_wr_en | input | 1 | Interrupt mask write strobe |
| mask_wr_data | input | 16 | Interrupt mask write word |
| status_set | input | 16 | Event pulses setting sticky status bits |
| status_clr_en | input | 1 | Status clear strobe |
| status_clr_data | input | 16 | Ones clear the matching sticky bits |
| status_rd_data | output | 16 | Status word |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same cycle. The first pair is a push and a pop. The bench drives both strobes at once at a middle level, at exactly 32 and at exactly 0, and compares the next fill level and the head word with the arithmetic of R5. The second pair is a configuration write that sets a DMA enable while the matching status flag is live. That case is judged by seeing the flag drop and the request rise in the same following cycle. Watermark outputs are checked at every fill level from 0 to 32, for several thresholds and for both DMA enable settings.

// File: rtl/mmc_data_fifo.sv
module mmc_data_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     dir_rx,
  input  logic                     xfer_active,
  input  logic                     fifo_flush,
  input  logic                     reg_wr_en,
  input  logic [DW-1:0]            reg_wr_data,
  input  logic                     reg_rd_en,
  output logic [DW-1:0]            reg_rd_data,
  input  logic                     card_push,
  input  logic [DW-1:0]            card_push_data,
  input  logic                     card_pop,
  output logic [DW-1:0]            card_pop_data,
  output logic [$clog2(DEPTH):0]   fill_level,
  input  logic                     cfg_wr_en,
  input  logic [15:0]              cfg_wr_data,
  output logic [15:0]              cfg_rd_data,
  input  logic                     mask_wr_en,
  input  logic [15:0]              mask_wr_data,
  input  logic [15:0]              status_set,
  input  logic                     status_clr_en,
  input  logic [15:0]              status_clr_data,
  output logic [15:0]              status_rd_data,
  output logic                     rx_dma_req,
  output logic                     tx_dma_req,
  output logic                     irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam int RXF = 10;
  localparam int TXF = 11;
  localparam logic [15:0] LIVE = (16'h1 << RXF) | (16'h1 << TXF);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] head;
  logic [CW-1:0] count;
  logic          rx_en, tx_en;
  logic [AW-1:0] af_lvl, ae_lvl;
  logic [14:0]   mask;
  logic [15:0]   sticky;

  logic          push_req, pop_req, do_push, do_pop;
  logic [DW-1:0] push_word;
  logic [AW-1:0] tail;

  assign push_req  = dir_rx ? card_push : reg_wr_en;
  assign push_word = dir_rx ? card_push_data : reg_wr_data;
  assign pop_req   = dir_rx ? reg_rd_en : card_pop;
  assign do_push   = push_req && (count != FULL) && !fifo_flush;
  assign do_pop    = pop_req && (count != '0) && !fifo_flush;
  assign tail      = head + count[AW-1:0];

  always_ff @(posedge clk) begin
    if (do_push) mem[tail] <= push_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      count <= '0;
    end else if (fifo_flush) begin
      head  <= '0;
      count <= '0;
    end else begin
      if (do_pop) head <= head + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  assign reg_rd_data   = mem[head];
  assign card_pop_data = mem[head];
  assign fill_level    = count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en  <= 1'b0;
      tx_en  <= 1'b0;
      af_lvl <= '1;
      ae_lvl <= '0;
    end else if (cfg_wr_en) begin
      rx_en  <= cfg_wr_data[15];
      af_lvl <= cfg_wr_data[8 +: AW];
      tx_en  <= cfg_wr_data[7];
      ae_lvl <= cfg_wr_data[0 +: AW];
    end
  end

  always_comb begin
    cfg_rd_data = '0;
    cfg_rd_data[15] = rx_en;
    cfg_rd_data[8 +: AW] = af_lvl;
    cfg_rd_data[7] = tx_en;
    cfg_rd_data[0 +: AW] = ae_lvl;
  end

  logic idle_empty, rx_hit, tx_hit, flag_rx, flag_tx;
  assign idle_empty = !xfer_active && (count == '0);
  assign rx_hit     = !idle_empty && dir_rx && (count > CW'(af_lvl));
  assign tx_hit     = !idle_empty && !dir_rx && (count < CW'(ae_lvl));
  assign rx_dma_req = rx_hit && rx_en;
  assign flag_rx    = rx_hit && !rx_en;
  assign tx_dma_req = tx_hit && tx_en;
  assign flag_tx    = tx_hit && !tx_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky <= '0;
      mask   <= '0;
    end else begin
      sticky <= ((sticky & ~(status_clr_en ? status_clr_data : 16'h0)) | status_set) & ~LIVE;
      if (mask_wr_en) mask <= mask_wr_data[14:0];
    end
  end

  always_comb begin
    status_rd_data = sticky;
    status_rd_data[RXF] = flag_rx;
    status_rd_data[TXF] = flag_tx;
  end

  assign irq = |(status_rd_data & {1'b0, mask});

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL && push_req && !pop_req && !fifo_flush) |=> (count == FULL));

  assert_bounded_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL);

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && pop_req && !push_req && !fifo_flush) |=> (count == '0 && $stable(head)));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_active && count == '0) |-> (!rx_dma_req && !tx_dma_req && status_rd_data[TXF:RXF] == 2'b00));

  assert_cfg_clears_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_wr_data[15]) |=> !status_rd_data[RXF]);

  assert_one_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_dma_req, tx_dma_req}));

  assert_flush_empties_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |=> (count == '0));
endmodule

// File: tb/tb_mmc_data_fifo.sv
module tb_mmc_data_fifo;
  logic clk = 0, rst_n = 0;
  logic dir_rx = 0, xfer_active = 0, fifo_flush = 0;
  logic reg_wr_en = 0, reg_rd_en = 0, card_push = 0, card_pop = 0;
  logic [15:0] reg_wr_data = 0, card_push_data = 0;
  logic [15:0] reg_rd_data, card_pop_data, cfg_rd_data, status_rd_data;
  logic [5:0]  fill_level;
  logic cfg_wr_en = 0, mask_wr_en = 0, status_clr_en = 0;
  logic [15:0] cfg_wr_data = 0, mask_wr_data = 0, status_set = 0, status_clr_data = 0;
  logic rx_dma_req, tx_dma_req, irq;
  int errors = 0, checks = 0;
  bit done = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  mmc_data_fifo dut (.*);

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic setup(input bit rx, input int cfg);
    dir_rx = rx; xfer_active = 1;
    cfg_wr_en = 1; cfg_wr_data = 16'(cfg); fifo_flush = 1;
    tick();
    cfg_wr_en = 0; fifo_flush = 0;
    chk(fill_level == 0, "R12 flush", fill_level, 0);
  endtask

  task automatic rx_round(input int en, input int af, input int tag);
    setup(1, (en << 15) | (af << 8));
    for (int n = 1; n <= 32; n++) begin
      card_push = 1; card_push_data = 16'(tag * 256 + n);
      tick();
      card_push = 0;
      chk(fill_level == n, "R2 level", fill_level, n);
      chk(rx_dma_req == (n > af && en == 1), "R6 rx req", rx_dma_req, int'(n > af && en == 1));
      chk(status_rd_data[10] == (n > af && en == 0), "R6 rx flag", status_rd_data[10], int'(n > af && en == 0));
      chk(tx_dma_req == 0, "R6 no tx req", tx_dma_req, 0);
    end
    card_push = 1; card_push_data = 16'hDEAD;
    tick();
    card_push = 0;
    chk(fill_level == 32, "R3 full push", fill_level, 32);
    for (int n = 1; n <= 32; n++) begin
      chk(reg_rd_data == 16'(tag * 256 + n), "R2 order", reg_rd_data, tag * 256 + n);
      reg_rd_en = 1;
      tick();
      reg_rd_en = 0;
      chk(fill_level == 32 - n, "R2 pop level", fill_level, 32 - n);
    end
    reg_rd_en = 1;
    tick();
    reg_rd_en = 0;
    chk(fill_level == 0, "R4 empty pop", fill_level, 0);
    chk(reg_rd_data == 16'(tag * 256 + 1), "R4 head word", reg_rd_data, tag * 256 + 1);
  endtask

  task automatic tx_round(input int en, input int ae, input int tag);
    setup(0, (en << 7) | ae);
    for (int n = 0; n <= 32; n++) begin
      if (n > 0) begin
        reg_wr_en = 1; reg_wr_data = 16'(tag * 256 + n);
        tick();
        reg_wr_en = 0;
      end
      chk(fill_level == n, "R2 level", fill_level, n);
      chk(tx_dma_req == (n < ae && en == 1), "R7 tx req", tx_dma_req, int'(n < ae && en == 1));
      chk(status_rd_data[11] == (n < ae && en == 0), "R7 tx flag", status_rd_data[11], int'(n < ae && en == 0));
      chk(rx_dma_req == 0, "R7 no rx req", rx_dma_req, 0);
    end
    for (int n = 1; n <= 32; n++) begin
      chk(card_pop_data == 16'(tag * 256 + n), "R2 order", card_pop_data, tag * 256 + n);
      card_pop = 1;
      tick();
      card_pop = 0;
    end
    chk(fill_level == 0, "R2 drained", fill_level, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=done", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk(fill_level == 0, "R1 level", fill_level, 0);
    chk(cfg_rd_data == 16'h1F00, "R1 cfg", cfg_rd_data, 16'h1F00);
    chk(!rx_dma_req && !tx_dma_req, "R1 req", {rx_dma_req, tx_dma_req}, 0);
    chk(irq == 0, "R1 irq", irq, 0);

    for (int en = 0; en < 2; en++) begin
      rx_round(en, 0, 16 + en);
      rx_round(en, 5, 32 + en);
      rx_round(en, 31, 48 + en);
      tx_round(en, 0, 64 + en);
      tx_round(en, 9, 80 + en);
      tx_round(en, 31, 96 + en);
    end

    // R8: idle and empty forces quiet outputs
    setup(0, 9);
    chk(status_rd_data[11] == 1, "R8 active flag", status_rd_data[11], 1);
    xfer_active = 0;
    tick();
    chk(status_rd_data[11:10] == 0, "R8 idle flags", status_rd_data[11:10], 0);
    setup(0, (1 << 7) | 9);
    xfer_active = 0;
    tick();
    chk(tx_dma_req == 0, "R8 idle req", tx_dma_req, 0);

    // R5: simultaneous push and pop
    setup(0, 0);
    for (int n = 1; n <= 32; n++) begin
      reg_wr_en = 1; reg_wr_data = 16'(n);
      tick();
    end
    reg_wr_en = 1; reg_wr_data = 16'h0BAD; card_pop = 1;
    tick();
    reg_wr_en = 0; card_pop = 0;
    chk(fill_level == 31, "R5 full both", fill_level, 31);
    chk(card_pop_data == 2, "R5 full head", card_pop_data, 2);
    for (int n = 0; n < 21; n++) begin card_pop = 1; tick(); end
    card_pop = 0;
    chk(fill_level == 10, "R5 mid setup", fill_level, 10);
    reg_wr_en = 1; reg_wr_data = 16'h0777; card_pop = 1;
    tick();
    reg_wr_en = 0; card_pop = 0;
    chk(fill_level == 10, "R5 mid both", fill_level, 10);
    chk(card_pop_data == 24, "R5 mid head", card_pop_data, 24);
    setup(0, 0);
    reg_wr_en = 1; reg_wr_data = 16'h0555; card_pop = 1;
    tick();
    reg_wr_en = 0; card_pop = 0;
    chk(fill_level == 1, "R5 empty both", fill_level, 1);
    chk(card_pop_data == 16'h0555, "R5 empty head", card_pop_data, 16'h0555);

    // R12: flush overrides a push
    reg_wr_en = 1; fifo_flush = 1;
    tick();
    reg_wr_en = 0; fifo_flush = 0;
    chk(fill_level == 0, "R12 flush over push", fill_level, 0);

    // R9: layout and enable clears flag
    cfg_wr_en = 1; cfg_wr_data = 16'hFFFF;
    tick();
    cfg_wr_en = 0;
    chk(cfg_rd_data == 16'h9F9F, "R9 layout", cfg_rd_data, 16'h9F9F);
    setup(1, 0);
    card_push = 1; card_push_data = 16'h1234;
    tick();
    card_push = 0;
    chk(status_rd_data[10] == 1, "R9 flag live", status_rd_data[10], 1);
    cfg_wr_en = 1; cfg_wr_data = 16'h8000;
    tick();
    cfg_wr_en = 0;
    chk(status_rd_data[10] == 0, "R9 flag cleared", status_rd_data[10], 0);
    chk(rx_dma_req == 1, "R9 request", rx_dma_req, 1);

    // R10 / R11: sticky status and interrupt
    cfg_wr_en = 1; cfg_wr_data = 16'h0000;
    tick();
    cfg_wr_en = 0;
    status_set = 16'h0008;
    tick();
    status_set = 0;
    chk(status_rd_data[3] == 1, "R10 set", status_rd_data[3], 1);
    chk(irq == 0, "R11 masked", irq, 0);
    mask_wr_en = 1; mask_wr_data = 16'h0008;
    tick();
    mask_wr_en = 0;
    chk(irq == 1, "R11 enabled", irq, 1);
    status_clr_en = 1; status_clr_data = 16'h0008; status_set = 16'h0008;
    tick();
    status_set = 0;
    chk(status_rd_data[3] == 1, "R10 set wins", status_rd_data[3], 1);
    tick();
    status_clr_en = 0;
    chk(status_rd_data[3] == 0, "R10 clear", status_rd_data[3], 0);
    chk(irq == 0, "R11 cleared", irq, 0);
    status_clr_en = 1; status_clr_data = 16'h0400;
    tick();
    status_clr_en = 0;
    chk(status_rd_data[10] == 1, "R10 live bit kept", status_rd_data[10], 1);
    mask_wr_en = 1; mask_wr_data = 16'h8000; status_set = 16'h8000;
    tick();
    mask_wr_en = 0; status_set = 0;
    chk(status_rd_data[15] == 1 && irq == 0, "R11 mask bit 15", irq, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule